// File: doc/BRIEF.md
# Push-Button Burst Capture Scanner

This block watches a bank of eight push buttons and turns a press into a single parallel snapshot for downstream selection logic. The button lines are first passed through a short synchroniser chain. When the OR of the synchronised lines goes from low to high while the block is idle, a sequencer issues a burst of exactly one shift strobe per button, one per clock. Each strobe moves one button level into a working shift register, highest-numbered button first, so that after the burst the register holds the whole button bank in its natural bit order.

On the clock edge that carries the last strobe, the completed byte is copied to the output register and a one-cycle valid pulse is raised. The output byte then stays put until the next capture completes. At the default settings a capture completes eleven clocks after the press reaches the input (0.22 us at 50 MHz), which is far shorter than any human press. A press that is still held, or any further press that arrives during a burst, cannot start another capture. Capture resumes only after every button has been released.

Top module: `btn_burst_scanner`

## Requirements
- R1: During and right after synchronous reset, `cap_o` is 0, `valid_o` is 0 and `busy_o` is 0.
- R2: A press from the all-released state makes `busy_o` rise on the third rising clock edge after the input change (two synchroniser stages plus one edge-detect register).
- R3: Once raised, `busy_o` stays high for exactly NUM_BTN (8) consecutive cycles, one shift strobe per cycle.
- R4: `valid_o` is high for exactly one cycle, on the edge where `busy_o` falls, and is otherwise low.
- R5: With the buttons held steady through the burst, bit i of `cap_o` equals the level of `btn_i[i]` (1 = pressed, 0 = released). The button with the highest index is sampled on the first strobe and button 0 on the last.
- R6: `cap_o` changes only on the edge that also raises `valid_o`. It holds its value while the block is idle and while a burst is in progress.
- R7: A press that becomes visible after synchronisation while `busy_o` is high, including a release followed by a new press within the same burst, starts no capture and produces no extra `valid_o`.
- R8: A held press, or a second button added while one is held, yields exactly one capture. A new capture needs all buttons released first.
- R9: The time from the input change to `valid_o` is SYNC_STAGES + 1 + NUM_BTN cycles (11 at the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| btn_i | input | 8 | Raw button levels, 1 = pressed |
| cap_o | output | 8 | Captured button byte, bit i = button i |
| valid_o | output | 1 | One-cycle pulse when a new byte is on `cap_o` |
| busy_o | output | 1 | High while the strobe burst is running |

## Verification
The hardest case to reach from the ports is a release and a new press that both land inside a single eight-cycle burst. The input must change after the first strobe has already sampled the button that is shifted in first, and the synchroniser delay must still expose the new edge to the start logic while `busy_o` is high. The bench presses button 7 only, releases it on the cycle the burst starts, and presses it again two cycles later. It then expects the byte 0x80, a single valid pulse, and no second capture while the button stays held. Every nonzero button pattern is also swept, with the latency, burst length and byte checked for each one.

// File: rtl/btn_scan_pkg.sv
package btn_scan_pkg;

  // Which button lane is sampled on a given strobe step. The first strobe
  // takes the top lane so that a left-shifting register ends in natural order.
  function automatic int lane_for_step(input int step, input int nbtn);
    return nbtn - 1 - step;
  endfunction

  // Cycles from an input change until the valid pulse is visible.
  function automatic int capture_latency(input int stages, input int nbtn);
    return stages + 1 + nbtn;
  endfunction

endpackage

// File: rtl/btn_sync_edge.sv
module btn_sync_edge #(
  parameter int NUM_BTN     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BTN-1:0] btn_raw_i,
  input  logic               busy_i,
  output logic [NUM_BTN-1:0] btn_s_o,
  output logic               start_o
);

  logic [NUM_BTN-1:0] chain [SYNC_STAGES];
  logic               any_now;
  logic               any_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= btn_raw_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign btn_s_o = chain[SYNC_STAGES-1];
  assign any_now = |btn_s_o;

  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= any_now;
  end

  assign start_o = any_now & ~any_q & ~busy_i;

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !busy_i);

  // R8
  start_edge_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq #(
  parameter int NUM_BTN = 8,
  localparam int CW     = $clog2(NUM_BTN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic          stb_o,
  output logic          last_o,
  output logic [CW-1:0] step_o,
  output logic          valid_o
);

  localparam logic [CW-1:0] LastStep = CW'(NUM_BTN - 1);

  logic          busy_q;
  logic [CW-1:0] step_q;
  logic          valid_q;

  assign stb_o  = busy_q;
  assign last_o = busy_q && (step_q == LastStep);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      step_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= last_o;
      if (start_i) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (busy_q) begin
        step_q <= step_q + 1'b1;
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign step_o  = step_q;
  assign valid_o = valid_q;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);

  // R3
  burst_end_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |=> !busy_o);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R4
  valid_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> valid_o);

endmodule

// File: rtl/shift_capture.sv
module shift_capture #(
  parameter int NUM_BTN = 8,
  localparam int CW     = $clog2(NUM_BTN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BTN-1:0] btn_s_i,
  input  logic               stb_i,
  input  logic               last_i,
  input  logic [CW-1:0]      step_i,
  output logic [NUM_BTN-1:0] cap_o
);

  import btn_scan_pkg::*;

  logic [NUM_BTN-1:0] work_q;
  logic [NUM_BTN-1:0] cap_q;
  logic [NUM_BTN-1:0] work_next;
  logic               lane_bit;

  always_comb begin
    lane_bit = 1'b0;
    for (int k = 0; k < NUM_BTN; k++) begin
      if (lane_for_step(int'(step_i), NUM_BTN) == k) lane_bit = btn_s_i[k];
    end
  end

  assign work_next = {work_q[NUM_BTN-2:0], lane_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      cap_q  <= '0;
    end else begin
      if (stb_i)  work_q <= work_next;
      if (last_i) cap_q  <= work_next;
    end
  end

  assign cap_o = cap_q;

  // R6
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !last_i |=> $stable(cap_o));

endmodule

// File: rtl/btn_burst_scanner.sv
module btn_burst_scanner #(
  parameter int NUM_BTN     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(NUM_BTN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BTN-1:0] btn_i,
  output logic [NUM_BTN-1:0] cap_o,
  output logic               valid_o,
  output logic               busy_o
);

  logic [NUM_BTN-1:0] btn_s;
  logic               start_stb;
  logic               shift_stb;
  logic               last_stb;
  logic [CW-1:0]      step;

  btn_sync_edge #(.NUM_BTN(NUM_BTN), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .btn_raw_i(btn_i), .busy_i(busy_o),
    .btn_s_o(btn_s), .start_o(start_stb)
  );

  strobe_seq #(.NUM_BTN(NUM_BTN)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_stb), .busy_o(busy_o),
    .stb_o(shift_stb), .last_o(last_stb), .step_o(step), .valid_o(valid_o)
  );

  shift_capture #(.NUM_BTN(NUM_BTN)) u_cap (
    .clk(clk), .rst(rst), .btn_s_i(btn_s), .stb_i(shift_stb),
    .last_i(last_stb), .step_i(step), .cap_o(cap_o)
  );

  // R4
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !busy_o);

endmodule

// File: tb/test_btn_burst_scanner.sv
module test_btn_burst_scanner;

  localparam int NB  = 8;
  localparam int SS  = 2;
  localparam int LAT = SS + 1 + NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] btn = '0;
  logic [NB-1:0] cap;
  logic          valid;
  logic          busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  btn_burst_scanner #(.NUM_BTN(NB), .SYNC_STAGES(SS)) i_btn_burst_scanner (
    .clk(clk), .rst(rst), .btn_i(btn), .cap_o(cap), .valid_o(valid), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // Drive a pattern and observe 30 cycles while it is held.
  task automatic observe(input logic [NB-1:0] pat, output int lat, output int rise,
                         output int bcyc, output int vcnt, output logic [NB-1:0] capv);
    @(negedge clk);
    btn = pat;
    lat = 0; rise = 0; bcyc = 0; vcnt = 0; capv = '0;
    for (int c = 1; c <= 30; c++) begin
      @(negedge clk);
      if (busy) begin
        bcyc++;
        if (rise == 0) rise = c;
      end
      if (valid) begin
        vcnt++;
        if (lat == 0) begin
          lat = c;
          capv = cap;
        end
      end
    end
  endtask

  task automatic release_all(input logic [NB-1:0] held);
    @(negedge clk);
    btn = '0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      // R6
      check(cap == held && !valid && !busy, "R6 hold while idle", int'(cap), int'(held));
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int lat, rise, bcyc, vcnt;
    logic [NB-1:0] capv;

    repeat (3) @(negedge clk);
    // R1
    check(cap == 0 && !valid && !busy, "R1 reset state", int'({cap, valid, busy}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(cap == 0 && !valid && !busy, "R1 after reset", int'({cap, valid, busy}), 0);

    for (int p = 1; p < (1 << NB); p++) begin
      observe(NB'(p), lat, rise, bcyc, vcnt, capv);
      // R2
      check(rise == SS + 1, "R2 busy rise", rise, SS + 1);
      // R3
      check(bcyc == NB, "R3 burst length", bcyc, NB);
      // R4 R8
      check(vcnt == 1, "R4 R8 single valid", vcnt, 1);
      // R9
      check(lat == LAT, "R9 latency", lat, LAT);
      // R5
      check(capv == NB'(p), "R5 captured byte", int'(capv), p);
      release_all(NB'(p));
    end

    // R8: add a second button while the first is held
    @(negedge clk);
    btn = 8'h01;
    repeat (5) @(negedge clk);
    btn = 8'h81;
    vcnt = 0; capv = '0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (valid) begin
        vcnt++;
        capv = cap;
      end
    end
    check(vcnt == 1, "R8 added button no recapture", vcnt, 1);
    check(capv == 8'h01, "R8 byte from first press", int'(capv), 1);
    release_all(8'h01);

    // R7: release and press again inside one burst
    @(negedge clk);
    btn = 8'h80;
    vcnt = 0; capv = '0;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      if (c == 3) btn = 8'h00;
      if (c == 5) btn = 8'h80;
      if (valid) begin
        vcnt++;
        capv = cap;
      end
    end
    check(vcnt == 1, "R7 press during busy ignored", vcnt, 1);
    check(capv == 8'h80, "R7 byte from first press", int'(capv), 8'h80);
    release_all(8'h80);

    // R1: reset mid-burst clears everything
    @(negedge clk);
    btn = 8'h3c;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    btn = '0;
    repeat (2) @(negedge clk);
    check(cap == 0 && !valid && !busy, "R1 reset mid burst", int'({cap, valid, busy}), 0);
    rst = 1'b0;

    finish_run();
  end

endmodule